// File: doc/BRIEF.md
# Interrupt Aggregation Controller

The block collects a parameterised set of single-bit interrupt request lines (at most 32) into one interrupt output for a processor. Each line has a trigger mode fixed by a parameter: it can react to a high level, a low level, a rising edge or a falling edge. A line that triggers while it is enabled latches a pending flag, and the output is raised whenever any flag is pending on an enabled line.

Software controls the block through four register views. The surrounding bus logic decodes the address and, for each write, presents a data word with a write strobe that is high for one clock cycle. One view sets enable bits, one clears them, one reads back the current enables, and one shows the pending flags and clears them. Writing 1 to a bit in any of the writable views acts on that bit. Writing 0 leaves it alone. Address decoding and the bus protocol are outside the block.

Top module: `irq_hub`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable mask, every pending flag and `irq_o` are all cleared to 0.
- R2: A write strobe on `en_wr` sets each mask bit whose `en_data` bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write strobe on `dis_wr` clears each mask bit whose `dis_data` bit is 1. When both strobes are high in the same cycle and name the same bit, that bit ends up cleared.
- R4: Mode 0 is active-high level. The pending flag is set at every clock edge where the line is 1 and its mask bit is 1. A disabled line sets nothing.
- R5: Mode 1 is rising edge. The flag is set only at the edge where the line is 1 and was 0 at the previous edge. A line held high does not set the flag again after a clear, and a falling edge sets nothing.
- R6: Mode 2 is falling edge. The flag is set only at the edge where the line is 0 and was 1 at the previous edge. A rising edge sets nothing.
- R7: Mode 3 is active-low level. The flag is set at every edge where the line is 0 and enabled.
- R8: A write strobe on `clr_wr` clears each pending flag whose `clr_data` bit is 1. Flags whose data bit is 0 are not affected.
- R9: When a clear and a new trigger hit the same pending bit in the same cycle, the flag stays set.
- R10: `irq_o` is registered. At each edge it takes the OR over all lines of (pending AND mask) as those registers held before that edge. Disabling a line drops its contribution, but its pending flag is kept.
- R11: With all strobes low, the data inputs have no effect on the mask or on the pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | NUM_LINES | Interrupt request lines |
| en_data | input | NUM_LINES | Enable register write data (1 = enable bit) |
| en_wr | input | 1 | Enable register write strobe |
| dis_data | input | NUM_LINES | Disable register write data (1 = disable bit) |
| dis_wr | input | 1 | Disable register write strobe |
| clr_data | input | NUM_LINES | Status register write data (1 = clear pending) |
| clr_wr | input | 1 | Status register write strobe |
| mask_o | output | NUM_LINES | Mask view, 1 = line enabled |
| pend_o | output | NUM_LINES | Status view, 1 = interrupt pending |
| irq_o | output | 1 | Aggregated interrupt output |

## Verification
The hardest case to reach is the collision, where a clear write and a new edge trigger land on the same bit in one clock cycle. Only then does the set-over-clear priority become visible. The bench places the clear strobe and the rising transition of an enabled edge-mode line on the same falling clock edge, so that both take effect at the next rising edge. It also clears a level-mode line while the line is still active, which shows that the flag is set again at once. In the same way, it writes enable and disable for one bit in a single cycle to show which of the two wins.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam int MAX_LINES = 32;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_RISE   = 2'd1,
    TRIG_FALL   = 2'd2,
    TRIG_LVL_LO = 2'd3
  } trig_mode_e;

  function automatic trig_mode_e mode_of(input logic [MAX_LINES*MODE_W-1:0] modes,
                                         input int idx);
    return trig_mode_e'(modes[idx*MODE_W +: MODE_W]);
  endfunction

endpackage

// File: rtl/irq_hub_detect.sv
module irq_hub_detect
  import irq_hub_pkg::*;
#(
  parameter int                               N     = 8,
  parameter logic [MAX_LINES*MODE_W-1:0]      MODES = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines,
  output logic [N-1:0] trig
);

  for (genvar i = 0; i < N; i++) begin : g_line
    localparam trig_mode_e M = mode_of(MODES, i);
    if (M == TRIG_RISE || M == TRIG_FALL) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        prev_q <= lines[i];
      end
      if (M == TRIG_RISE) begin : g_rise
        assign trig[i] = lines[i] & ~prev_q & rst_n;
      end else begin : g_fall
        assign trig[i] = ~lines[i] & prev_q & rst_n;
      end
    end else if (M == TRIG_LVL_HI) begin : g_hi
      assign trig[i] = lines[i];
    end else begin : g_lo
      assign trig[i] = ~lines[i];
    end
  end

endmodule

// File: rtl/irq_hub_mask.sv
module irq_hub_mask #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] en_data,
  input  logic         en_wr,
  input  logic [N-1:0] dis_data,
  input  logic         dis_wr,
  output logic [N-1:0] mask_q
);

  logic [N-1:0] set_bits;
  logic [N-1:0] clr_bits;

  always_comb begin
    set_bits = en_wr  ? en_data  : '0;
    clr_bits = dis_wr ? dis_data : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else begin
      mask_q <= (mask_q | set_bits) & ~clr_bits;
    end
  end

endmodule

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] clr_data,
  input  logic         clr_wr,
  output logic [N-1:0] pend_q
);

  logic [N-1:0] clr_bits;
  logic [N-1:0] new_bits;

  always_comb begin
    clr_bits = clr_wr ? clr_data : '0;
    new_bits = trig & mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits) | new_bits;
    end
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int                          NUM_LINES  = 8,
  parameter logic [MAX_LINES*MODE_W-1:0] LINE_MODES = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic [NUM_LINES-1:0] en_data,
  input  logic                 en_wr,
  input  logic [NUM_LINES-1:0] dis_data,
  input  logic                 dis_wr,
  input  logic [NUM_LINES-1:0] clr_data,
  input  logic                 clr_wr,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 irq_o
);

  logic [NUM_LINES-1:0] trig_w;
  logic [NUM_LINES-1:0] mask_w;
  logic [NUM_LINES-1:0] pend_w;
  logic                 irq_q;

  irq_hub_detect #(.N(NUM_LINES), .MODES(LINE_MODES)) u_detect (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (irq_lines),
    .trig  (trig_w)
  );

  irq_hub_mask #(.N(NUM_LINES)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_data  (en_data),
    .en_wr    (en_wr),
    .dis_data (dis_data),
    .dis_wr   (dis_wr),
    .mask_q   (mask_w)
  );

  irq_hub_pend #(.N(NUM_LINES)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig_w),
    .mask     (mask_w),
    .clr_data (clr_data),
    .clr_wr   (clr_wr),
    .pend_q   (pend_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= |(pend_w & mask_w);
    end
  end

  assign mask_o = mask_w;
  assign pend_o = pend_w;
  assign irq_o  = irq_q;

endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] trig,
  input logic [N-1:0] en_data,
  input logic         en_wr,
  input logic [N-1:0] dis_data,
  input logic         dis_wr,
  input logic [N-1:0] clr_data,
  input logic         clr_wr,
  input logic [N-1:0] mask,
  input logic [N-1:0] pend,
  input logic         irq
);

  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (mask == '0 && pend == '0 && irq == 1'b0));

  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !dis_wr) |=> ((mask & $past(en_data)) == $past(en_data)));

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> ((mask & $past(dis_data)) == '0));

  a_r4_set_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(mask)) == '0));

  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pend & $past(clr_data) & ~$past(trig & mask)) == '0));

  a_r9_trigger_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && ((trig & mask) != '0)) |=> ((pend & $past(trig & mask)) == $past(trig & mask)));

  a_r10_irq_aggregate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == |($past(pend & mask))));

  a_r11_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_wr && !dis_wr) |=> $stable(mask));

endmodule

bind irq_hub irq_hub_checker #(.N(NUM_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig_w),
  .en_data  (en_data),
  .en_wr    (en_wr),
  .dis_data (dis_data),
  .dis_wr   (dis_wr),
  .clr_data (clr_data),
  .clr_wr   (clr_wr),
  .mask     (mask_w),
  .pend     (pend_w),
  .irq      (irq_q)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  // line0 level-high, line1 rising, line2 falling, line3 level-low, rest level-high
  localparam logic [63:0] MODES = 64'h0000_0000_0000_00E4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq_lines, en_data, dis_data, clr_data;
  logic         en_wr, dis_wr, clr_wr;
  logic [N-1:0] mask_o, pend_o;
  logic         irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub #(.NUM_LINES(N), .LINE_MODES(MODES)) u_irq_hub (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .en_data(en_data), .en_wr(en_wr), .dis_data(dis_data), .dis_wr(dis_wr),
    .clr_data(clr_data), .clr_wr(clr_wr),
    .mask_o(mask_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [N-1:0] d);
    en_data = d; en_wr = 1'b1; step(); en_wr = 1'b0; en_data = '0;
  endtask

  task automatic wr_dis(input logic [N-1:0] d);
    dis_data = d; dis_wr = 1'b1; step(); dis_wr = 1'b0; dis_data = '0;
  endtask

  task automatic wr_clr(input logic [N-1:0] d);
    clr_data = d; clr_wr = 1'b1; step(); clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check("R1 mask", 32'(mask_o), 0);
    check("R1 pend", 32'(pend_o), 0);
    check("R1 irq", 32'(irq_o), 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_mask();
    wr_en(8'h05);
    check("R2 enable sets", 32'(mask_o), 32'h05);
    wr_en(8'h10);
    check("R2 zero bits keep", 32'(mask_o), 32'h15);
    wr_dis(8'h04);
    check("R3 disable clears", 32'(mask_o), 32'h11);
    en_data = 8'h20; en_wr = 1'b1; dis_data = 8'h21; dis_wr = 1'b1;
    step();
    en_wr = 1'b0; dis_wr = 1'b0; en_data = '0; dis_data = '0;
    check("R3 disable wins", 32'(mask_o), 32'h10);
    wr_dis(8'hFF);
    check("R3 disable all", 32'(mask_o), 0);
  endtask

  task automatic t_no_strobe();
    en_data = 8'hFF; clr_data = 8'hFF; dis_data = 8'h00;
    step(); step();
    check("R11 mask untouched", 32'(mask_o), 0);
    check("R11 pend untouched", 32'(pend_o), 0);
    en_data = '0; clr_data = '0;
  endtask

  task automatic t_level_hi();
    irq_lines[0] = 1'b1;
    step();
    check("R4 disabled ignored", 32'(pend_o), 0);
    wr_en(8'h01);
    check("R4 not yet", 32'(pend_o), 0);
    step();
    check("R4 level sets", 32'(pend_o), 32'h01);
    check("R10 irq lags", 32'(irq_o), 0);
    step();
    check("R10 irq high", 32'(irq_o), 1);
    wr_clr(8'h01);
    check("R4 level re-sets", 32'(pend_o), 32'h01);
    irq_lines[0] = 1'b0;
    wr_clr(8'h01);
    check("R8 clear", 32'(pend_o), 0);
    step();
    check("R10 irq drops", 32'(irq_o), 0);
    wr_dis(8'h01);
  endtask

  task automatic t_rise();
    wr_en(8'h02);
    irq_lines[1] = 1'b1;
    step();
    check("R5 rise sets", 32'(pend_o), 32'h02);
    wr_clr(8'h02);
    check("R5 cleared", 32'(pend_o), 0);
    step();
    check("R5 held high no set", 32'(pend_o), 0);
    irq_lines[1] = 1'b0;
    step();
    check("R5 fall ignored", 32'(pend_o), 0);
    irq_lines[1] = 1'b1;
    step();
    step();
    check("R10 irq on edge", 32'(irq_o), 1);
    wr_dis(8'h02);
    check("R10 irq old mask", 32'(irq_o), 1);
    step();
    check("R10 masked irq low", 32'(irq_o), 0);
    check("R10 pend kept", 32'(pend_o), 32'h02);
    wr_clr(8'h02);
    irq_lines[1] = 1'b0;
    step();
  endtask

  task automatic t_fall();
    wr_en(8'h04);
    irq_lines[2] = 1'b0;
    step();
    check("R6 fall sets", 32'(pend_o), 32'h04);
    wr_clr(8'h04);
    irq_lines[2] = 1'b1;
    step();
    check("R6 rise ignored", 32'(pend_o), 0);
    irq_lines[2] = 1'b0;
    step();
    wr_clr(8'h00);
    check("R8 zero no effect", 32'(pend_o), 32'h04);
    wr_clr(8'h04);
    check("R8 clear fall", 32'(pend_o), 0);
    wr_dis(8'h04);
    irq_lines[2] = 1'b1;
    step();
  endtask

  task automatic t_level_lo();
    wr_en(8'h08);
    step();
    check("R7 high idle", 32'(pend_o), 0);
    irq_lines[3] = 1'b0;
    step();
    check("R7 low sets", 32'(pend_o), 32'h08);
    irq_lines[3] = 1'b1;
    wr_clr(8'h08);
    check("R7 cleared", 32'(pend_o), 0);
    wr_dis(8'h08);
  endtask

  task automatic t_collide();
    wr_en(8'h02);
    irq_lines[1] = 1'b1; clr_data = 8'h02; clr_wr = 1'b1;
    step();
    clr_wr = 1'b0; clr_data = '0;
    check("R9 trigger wins", 32'(pend_o), 32'h02);
    wr_dis(8'h02);
    wr_clr(8'h02);
    irq_lines[1] = 1'b0;
    step();
    check("R9 cleanup", 32'(pend_o), 0);
  endtask

  task automatic t_multi();
    wr_en(8'h30);
    irq_lines[5:4] = 2'b11;
    step(); step();
    check("R10 multi pend", 32'(pend_o), 32'h30);
    irq_lines[4] = 1'b0;
    wr_clr(8'h10);
    check("R10 one left", 32'(pend_o), 32'h20);
    step();
    check("R10 or stays", 32'(irq_o), 1);
  endtask

  initial begin
    irq_lines = 8'h0C;
    en_data = '0; dis_data = '0; clr_data = '0;
    en_wr = 1'b0; dis_wr = 1'b0; clr_wr = 1'b0;
    rst_n = 1'b0;
    step();
    t_reset();
    t_mask();
    t_no_strobe();
    t_level_hi();
    t_rise();
    t_fall();
    t_level_lo();
    t_collide();
    t_multi();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule